// File: doc/BRIEF.md
# Video Clamp Pulse Generator

This block produces one clamp strobe per video line for a three-channel video digitizer. The strobe is placed in the back porch. A counter started by the falling (trailing) edge of horizontal sync waits a programmed number of pixel clocks, then holds the strobe for a programmed number of pixel clocks. A settings pair of 4 and 40 pixel periods is a reasonable start for common graphics timings.

The counter can be bypassed. When the source select is set, an external clamp input drives the strobe directly, and its active level is set by a polarity input. The block also gives each channel a clamp target code, either ground (0) or midscale (128), so that RGB inputs and luma/colour-difference inputs can be clamped correctly. Configuration arrives on static ports. The strobe is never asserted while sync is high.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released, `clamp_o` is 0 and every field of `lvl_code_o` is 0 until configured otherwise.
- R2: In internal mode (`cfg_src_ext`=0), `clamp_o` rises P clock edges after the trailing-edge edge, where P is `cfg_place` (0..255). The trailing-edge edge is the first rising clock edge that samples `hsync_in` low after sampling it high.
- R3: In internal mode the strobe stays high for exactly D consecutive cycles, where D is `cfg_dur` (1..255).
- R4: With `cfg_dur`=0 no strobe is produced on that line.
- R5: With `cfg_place`=0 the strobe goes high on the trailing-edge edge itself.
- R6: A new trailing edge of sync restarts the placement count and ends any strobe still in progress. The next strobe is timed from the new edge.
- R7: `clamp_o` is 0 in every cycle following a clock edge that sampled `hsync_in` high, in both modes.
- R8: With `cfg_src_ext`=1, `clamp_o` one cycle later equals 1 when `ext_clamp_in` equals `cfg_ext_pol` (1 = active high, 0 = active low). Sync trailing edges then produce no strobe.
- R9: Channel i's code occupies `lvl_code_o[8i+7:8i]`. It becomes 128 one cycle after `cfg_mid_sel[i]` is 1, and 0 one cycle after it is 0.
- R10: The leading (rising) edge of `hsync_in` never starts a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| ext_clamp_in | input | 1 | External clamp request |
| cfg_src_ext | input | 1 | 1 selects the external clamp input |
| cfg_ext_pol | input | 1 | Active level of the external clamp input |
| cfg_place | input | 8 | Delay from sync trailing edge, in pixel clocks |
| cfg_dur | input | 8 | Strobe length, in pixel clocks |
| cfg_mid_sel | input | 3 | Per-channel midscale select (1 = code 128) |
| clamp_o | output | 1 | Registered clamp strobe |
| lvl_code_o | output | 24 | Three 8-bit clamp target codes, channel 0 in the low byte |

## Verification
The embedded assertions check on every cycle that the strobe is low after any edge that sampled sync high. They also check that a zero duration leaves the timer idle, that a trailing edge with nonzero settings always re-enters the wait phase, that a hold ends on its last count, and that the external path follows the request at the selected polarity. They further check that each level code is always either ground or midscale. The exact start offset and width of the strobe across many placement and duration pairs can only be shown by the bench's scenarios. The same holds for the abort-and-restart on a fresh sync pulse and for the silence of the counter in external mode.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } tmr_state_t;
endpackage

// File: rtl/clamp_rst_sync.sv
module clamp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= 2'b00;
    else        shreg_q <= {shreg_q[0], 1'b1};
  end

  assign rst_n_sync = shreg_q[1];
endmodule

// File: rtl/clamp_sync_edge.sv
module clamp_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_i,
  output logic hs_q_o,
  output logic trail_o
);
  logic hs_q;
  logic hs_n;

  always_comb hs_n = hsync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 1'b0;
    else        hs_q <= hs_n;
  end

  // falling edge seen at this clock edge: previous sample high, current low
  assign trail_o = hs_q & ~hsync_i;
  assign hs_q_o  = hs_q;
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
  import clamp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trail_i,
  input  logic             hsync_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             hold_nxt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tmr_state_t       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (hsync_i) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else if (trail_i) begin
      if (dur_i == '0) begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end else if (place_i == '0) begin
        st_n  = ST_HOLD;
        cnt_n = dur_i - ONE;
      end else begin
        st_n  = ST_WAIT;
        cnt_n = place_i - ONE;
      end
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (cnt_q == '0) begin
            if (dur_i == '0) begin
              st_n  = ST_IDLE;
              cnt_n = '0;
            end else begin
              st_n  = ST_HOLD;
              cnt_n = dur_i - ONE;
            end
          end else begin
            cnt_n = cnt_q - ONE;
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) st_n = ST_IDLE;
          else             cnt_n = cnt_q - ONE;
        end
        default: begin
          st_n  = ST_IDLE;
          cnt_n = cnt_q;
        end
      endcase
    end
  end

  assign cnt_en = (st_q != ST_IDLE) || (st_n != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign hold_nxt_o = (st_n == ST_HOLD);

  AST_ZERO_DUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_i && dur_i == '0) |=> (st_q == ST_IDLE)); // R4
  AST_TRAIL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_i && dur_i != '0 && place_i != '0) |=> (st_q == ST_WAIT)); // R6
  AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_i |=> (st_q == ST_IDLE)); // R7
  AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && cnt_q == '0 && !trail_i) |=> (st_q == ST_IDLE)); // R3
endmodule

// File: rtl/clamp_out_stage.sv
module clamp_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext_i,
  input  logic ext_pol_i,
  input  logic ext_in_i,
  input  logic int_hold_nxt_i,
  input  logic hsync_i,
  input  logic hs_q_i,
  output logic clamp_o
);
  logic ext_act;
  logic clamp_n;
  logic clamp_q;

  always_comb begin
    ext_act = (ext_in_i == ext_pol_i);
    clamp_n = (src_ext_i ? ext_act : int_hold_nxt_i) & ~hsync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamp_q <= 1'b0;
    else        clamp_q <= clamp_n;
  end

  assign clamp_o = clamp_q;

  AST_NO_CLAMP_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    hs_q_i |-> !clamp_q); // R7
  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext_i && !hsync_i) |=> (clamp_q == ($past(ext_in_i) == $past(ext_pol_i)))); // R8
endmodule

// File: rtl/clamp_level_sel.sv
module clamp_level_sel #(
  parameter int NCH    = 3,
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        mid_sel_i,
  output logic [NCH*CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CODE_W-1:0] code_q, code_n;

    always_comb code_n = mid_sel_i[ch] ? MID : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_n;
    end

    assign code_o[ch*CODE_W +: CODE_W] = code_q;

    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == '0) || (code_q == MID)); // R9
  end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int NCH    = 3,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                  clk_pix,
  input  logic                  rst_n,
  input  logic                  hsync_in,
  input  logic                  ext_clamp_in,
  input  logic                  cfg_src_ext,
  input  logic                  cfg_ext_pol,
  input  logic [CNT_W-1:0]      cfg_place,
  input  logic [CNT_W-1:0]      cfg_dur,
  input  logic [NCH-1:0]        cfg_mid_sel,
  output logic                  clamp_o,
  output logic [NCH*CODE_W-1:0] lvl_code_o
);
  logic rst_n_s;
  logic hs_q;
  logic trail;
  logic hold_nxt;

  clamp_rst_sync u_rst (
    .clk        (clk_pix),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  clamp_sync_edge u_edge (
    .clk     (clk_pix),
    .rst_n   (rst_n_s),
    .hsync_i (hsync_in),
    .hs_q_o  (hs_q),
    .trail_o (trail)
  );

  clamp_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk_pix),
    .rst_n      (rst_n_s),
    .trail_i    (trail),
    .hsync_i    (hsync_in),
    .place_i    (cfg_place),
    .dur_i      (cfg_dur),
    .hold_nxt_o (hold_nxt)
  );

  clamp_out_stage u_out (
    .clk            (clk_pix),
    .rst_n          (rst_n_s),
    .src_ext_i      (cfg_src_ext),
    .ext_pol_i      (cfg_ext_pol),
    .ext_in_i       (ext_clamp_in),
    .int_hold_nxt_i (hold_nxt),
    .hsync_i        (hsync_in),
    .hs_q_i         (hs_q),
    .clamp_o        (clamp_o)
  );

  clamp_level_sel #(.NCH(NCH), .CODE_W(CODE_W)) u_lvl (
    .clk       (clk_pix),
    .rst_n     (rst_n_s),
    .mid_sel_i (cfg_mid_sel),
    .code_o    (lvl_code_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk_pix) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> !clamp_o); // R1
endmodule

// File: tb/test_clamp_pulse_gen.sv
module test_clamp_pulse_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hsync_in, ext_clamp_in, cfg_src_ext, cfg_ext_pol;
  logic [7:0]  cfg_place, cfg_dur;
  logic [2:0]  cfg_mid_sel;
  logic        clamp_o;
  logic [23:0] lvl_code_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  clamp_pulse_gen i_clamp_pulse_gen (
    .clk_pix(clk), .rst_n(rst_n), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
    .cfg_src_ext(cfg_src_ext), .cfg_ext_pol(cfg_ext_pol), .cfg_place(cfg_place),
    .cfg_dur(cfg_dur), .cfg_mid_sel(cfg_mid_sel), .clamp_o(clamp_o), .lvl_code_o(lvl_code_o)
  );

  // {place, dur}
  localparam logic [15:0] VEC [6] = '{
    {8'd4,   8'd40},
    {8'd0,   8'd5},
    {8'd1,   8'd1},
    {8'd10,  8'd0},
    {8'd255, 8'd3},
    {8'd3,   8'd255}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  // sample k = 0 is right after the trailing-edge clock edge
  task automatic measure(input int limit, output int first, output int width);
    first = -1;
    width = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (clamp_o) begin
        if (first < 0) first = k;
        width++;
      end
    end
  endtask

  // raise sync for 3 cycles (checks R7/R10 there), drop it at a negedge
  task automatic sync_pulse();
    int seen;
    seen = 0;
    hsync_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (clamp_o) seen++;
    end
    chk("R10 no strobe from leading edge / R7 sync high", seen, 0);
    hsync_in = 1'b0;
  endtask

  initial begin
    int first, width;
    rst_n = 1'b0; hsync_in = 1'b0; ext_clamp_in = 1'b0;
    cfg_src_ext = 1'b0; cfg_ext_pol = 1'b1;
    cfg_place = 8'd4; cfg_dur = 8'd40; cfg_mid_sel = 3'b000;
    repeat (3) @(negedge clk);
    chk("R1 clamp in reset", int'(clamp_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 clamp after reset", int'(clamp_o), 0);
    chk("R1 codes after reset", int'(lvl_code_o), 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 6; v++) begin
      cfg_place = VEC[v][15:8];
      cfg_dur   = VEC[v][7:0];
      @(negedge clk);
      sync_pulse();
      measure(int'(cfg_place) + int'(cfg_dur) + 8, first, width);
      chk($sformatf("R2/R5/R4 start v%0d", v), first,
          (cfg_dur == 0) ? -1 : int'(cfg_place));
      chk($sformatf("R3/R4 width v%0d", v), width, int'(cfg_dur));
    end

    // R6: abort in progress, restart from new edge
    cfg_place = 8'd5; cfg_dur = 8'd20;
    @(negedge clk);
    sync_pulse();
    repeat (8) @(negedge clk);
    chk("R6 strobe running before abort", int'(clamp_o), 1);
    hsync_in = 1'b1;
    @(negedge clk);
    chk("R7 strobe cut by sync", int'(clamp_o), 0);
    @(negedge clk);
    hsync_in = 1'b0;
    measure(40, first, width);
    chk("R6 restart start", first, 5);
    chk("R6 restart width", width, 20);

    // R8 external source
    cfg_src_ext = 1'b1; cfg_ext_pol = 1'b1;
    ext_clamp_in = 1'b1;
    @(negedge clk);
    chk("R8 ext active high on", int'(clamp_o), 1);
    hsync_in = 1'b1;
    @(negedge clk);
    chk("R7 ext gated by sync", int'(clamp_o), 0);
    hsync_in = 1'b0;
    ext_clamp_in = 1'b0;
    @(negedge clk);
    chk("R8 ext active high off", int'(clamp_o), 0);
    cfg_ext_pol = 1'b0;
    @(negedge clk);
    chk("R8 ext active low on", int'(clamp_o), 1);
    ext_clamp_in = 1'b1;
    @(negedge clk);
    chk("R8 ext active low off", int'(clamp_o), 0);
    cfg_place = 8'd0; cfg_dur = 8'd10;
    sync_pulse();
    measure(20, first, width);
    chk("R8 counter ignored in ext mode", width, 0);
    cfg_src_ext = 1'b0; ext_clamp_in = 1'b0; cfg_ext_pol = 1'b1;

    // R9 level codes
    cfg_mid_sel = 3'b101;
    @(negedge clk);
    chk("R9 codes 101", int'(lvl_code_o), 24'h800080);
    cfg_mid_sel = 3'b010;
    @(negedge clk);
    chk("R9 codes 010", int'(lvl_code_o), 24'h008000);

    finish_run();
  end
endmodule